// File: doc/BRIEF.md
# Record Ring Control Registers

This block keeps the control and status state for a ring of records held in memory. A hardware unit fills the ring and software drains it. The block suits fault records and, used a second time, page-request records. Software reaches the state through a simple register port with a write strobe and an address. The same address also selects the read data, without a clock. The producing unit asks for a slot on a request line. In the same cycle it gets either a grant with the slot index or an overflow indication. Later it signals that the record has been committed to memory. Record formatting and the memory writes are not handled here.

The unit owns the tail index and software owns the head index. Turning the ring on clears the tail and the sticky error flags, and the ring becomes active only after a fixed activation delay. Turning it off lets the slots already granted drain before the ring reports itself inactive. After that, no further slot can be granted.

Top module: `recRingCtl`

## Requirements
- R1: After reset, every register reads 0: base, head, tail and the control/status word. The ring is off and not busy.
- R2: Address 0 holds the base register: the log2-size-minus-one field in bits [LSZ_W-1:0] and the page number above it. A write stores both fields and forces the head to 0. The ring size is 2^min(field+1, IDX_W).
- R3: A write to address 1 sets the head to the written value masked to the index width of the current ring size. A write to address 2, which holds the tail, has no effect.
- R4: Address 3 is the control/status word: enable bit 0, overflow bit 1, memory-fault bit 2, on bit 8, busy bit 9. Writing enable 1 while it is 0 zeroes the tail and clears both flags. The word then reads busy=1, on=0 for ACT_DELAY cycles, and after that on=1, busy=0.
- R5: While busy is 1, a write to the control/status word is ignored entirely, including its flag-clear bits.
- R6: A slot request is granted in the same cycle only when on=1, busy=0, enable=1, both flags are 0 and the ring is not full. The granted index is (tail + in-flight count) mod size.
- R7: A commit moves the tail forward by one modulo the ring size and retires one in-flight slot. A commit with no slot in flight has no effect.
- R8: The ring is full when (tail + in-flight + 1) mod size equals the head. An eligible request to a full ring is dropped: the overflow output pulses and the overflow flag sets. The flag is sticky and blocks all further grants.
- R9: The overflow and memory-fault flags are cleared by writing 1 to their bit. A pulse on the memory-fault input sets the memory-fault flag, which blocks grants until it is cleared. If a set and a clear arrive in the same cycle, the set wins.
- R10: Writing enable 0 while it is 1 makes enable read 0 at once and stops new grants. on=1 and busy=1 hold until every in-flight slot is committed, and one cycle later on and busy both read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register select, for both write and read |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Read data of the register selected by regAddr |
| slotReq | input | 1 | Producer asks for a slot |
| slotGrant | output | 1 | Slot granted this cycle |
| slotOvf | output | 1 | Request dropped because the ring is full |
| slotIdx | output | IDX_W | Index of the granted slot |
| recCommit | input | 1 | Producer finished writing its oldest granted record |
| memFaultIn | input | 1 | Pulse reporting a memory fault on a record write |

## Verification
Directed cases fill a ring of eight slots to exactly seven grants and then make one more request. This separates the full test from an off-by-one. They also wrap the tail past the top index and commit with nothing in flight. Disabling with two slots outstanding shows that on stays up through the drain and drops exactly one cycle after the last commit. A long random mix of requests, commits, head updates by software and flag clears follows. It is compared every cycle against a bench model of the grant, overflow and index outputs, and it exercises grant and commit in the same cycle, which a directed list would miss. A base write with an oversized size field checks that the head mask is clamped to the index width.

// File: rtl/recring_pkg.sv
package recring_pkg;

  typedef enum logic [1:0] {
    ST_OFF,
    ST_ACT,
    ST_ON,
    ST_DRAIN
  } ringState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic actStart;
    logic clrOvf;
    logic clrMf;
    logic allowGrant;
  } ringStrobe_t;

  localparam logic [1:0] ADDR_BASE = 2'd0;
  localparam logic [1:0] ADDR_HEAD = 2'd1;
  localparam logic [1:0] ADDR_TAIL = 2'd2;
  localparam logic [1:0] ADDR_CSR  = 2'd3;

  localparam int CSR_EN   = 0;
  localparam int CSR_OVF  = 1;
  localparam int CSR_MF   = 2;
  localparam int CSR_ON   = 8;
  localparam int CSR_BUSY = 9;

endpackage

// File: rtl/recRingCtrl.sv
module recRingCtrl
  import recring_pkg::*;
#(
  parameter int ACT_DELAY = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        csrWr,
  input  logic [2:0]  csrData,
  input  logic        inflightZero,
  output ringStrobe_t strobe,
  output logic        enQ,
  output logic        onOut,
  output logic        busyOut
);

  localparam int CNT_W = $clog2(ACT_DELAY + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(ACT_DELAY - 1);

  ringState_t stateQ;
  logic [CNT_W-1:0] cntQ;
  logic csrAccept;
  logic deact;

  always_comb begin
    busyOut   = (stateQ == ST_ACT) || (stateQ == ST_DRAIN);
    onOut     = (stateQ == ST_ON) || (stateQ == ST_DRAIN);
    csrAccept = csrWr && !busyOut;
    strobe.actStart   = csrAccept && csrData[CSR_EN] && !enQ;
    strobe.clrOvf     = csrAccept && csrData[CSR_OVF];
    strobe.clrMf      = csrAccept && csrData[CSR_MF];
    strobe.allowGrant = (stateQ == ST_ON);
    deact             = csrAccept && !csrData[CSR_EN] && enQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_OFF;
      cntQ   <= '0;
      enQ    <= 1'b0;
    end else begin
      if (strobe.actStart) enQ <= 1'b1;
      else if (deact)      enQ <= 1'b0;
      unique case (stateQ)
        ST_OFF: begin
          if (strobe.actStart) begin
            stateQ <= ST_ACT;
            cntQ   <= CNT_LOAD;
          end
        end
        ST_ACT: begin
          if (cntQ == '0) stateQ <= ST_ON;
          else            cntQ   <= cntQ - 1'b1;
        end
        ST_ON: begin
          if (deact) stateQ <= ST_DRAIN;
        end
        ST_DRAIN: begin
          if (inflightZero) stateQ <= ST_OFF;
        end
        default: stateQ <= ST_OFF;
      endcase
    end
  end

endmodule

// File: rtl/recRingDp.sv
module recRingDp
  import recring_pkg::*;
#(
  parameter int PPN_W = 20,
  parameter int LSZ_W = 5,
  parameter int IDX_W = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  ringStrobe_t            strobe,
  input  logic                   baseWr,
  input  logic                   headWr,
  input  logic [PPN_W+LSZ_W-1:0] wrData,
  input  logic                   slotReq,
  input  logic                   recCommit,
  input  logic                   memFaultIn,
  output logic                   slotGrant,
  output logic                   slotOvf,
  output logic [IDX_W-1:0]       slotIdx,
  output logic [PPN_W-1:0]       ppnQ,
  output logic [LSZ_W-1:0]       lsm1Q,
  output logic [IDX_W-1:0]       headQ,
  output logic [IDX_W-1:0]       tailQ,
  output logic                   ovfQ,
  output logic                   mfQ,
  output logic                   inflightZero
);

  localparam logic [LSZ_W:0] IDX_LIM = (LSZ_W+1)'(IDX_W);

  logic [IDX_W-1:0] inflightQ;
  logic [IDX_W-1:0] idxMask;
  logic [LSZ_W:0]   lszRaw;
  logic [LSZ_W:0]   lszEff;
  logic [IDX_W-1:0] allocIdx;
  logic             ringFull;
  logic             eligible;
  logic             commitOk;

  always_comb begin
    lszRaw = {1'b0, lsm1Q} + (LSZ_W+1)'(1);
    lszEff = (lszRaw > IDX_LIM) ? IDX_LIM : lszRaw;
  end

  // one mask bit per index bit below the effective log2 size
  for (genvar i = 0; i < IDX_W; i++) begin : g_mask
    assign idxMask[i] = (lszEff > (LSZ_W+1)'(i));
  end

  always_comb begin
    allocIdx     = (tailQ + inflightQ) & idxMask;
    ringFull     = (((allocIdx + 1'b1) & idxMask) == headQ);
    eligible     = strobe.allowGrant && !ovfQ && !mfQ;
    slotGrant    = slotReq && eligible && !ringFull;
    slotOvf      = slotReq && eligible && ringFull;
    slotIdx      = allocIdx;
    commitOk     = recCommit && (inflightQ != '0);
    inflightZero = (inflightQ == '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ppnQ      <= '0;
      lsm1Q     <= '0;
      headQ     <= '0;
      tailQ     <= '0;
      inflightQ <= '0;
      ovfQ      <= 1'b0;
      mfQ       <= 1'b0;
    end else begin
      if (baseWr) begin
        lsm1Q <= wrData[LSZ_W-1:0];
        ppnQ  <= wrData[LSZ_W +: PPN_W];
        headQ <= '0;
      end else if (headWr) begin
        headQ <= wrData[IDX_W-1:0] & idxMask;
      end

      if (strobe.actStart)  tailQ <= '0;
      else if (commitOk)    tailQ <= (tailQ + 1'b1) & idxMask;

      inflightQ <= inflightQ + IDX_W'(slotGrant) - IDX_W'(commitOk);

      if (strobe.actStart)    ovfQ <= 1'b0;
      else if (slotOvf)       ovfQ <= 1'b1;
      else if (strobe.clrOvf) ovfQ <= 1'b0;

      if (strobe.actStart)    mfQ <= 1'b0;
      else if (memFaultIn)    mfQ <= 1'b1;
      else if (strobe.clrMf)  mfQ <= 1'b0;
    end
  end

endmodule

// File: rtl/recRingCtl.sv
module recRingCtl
  import recring_pkg::*;
#(
  parameter int PPN_W     = 20,
  parameter int LSZ_W     = 5,
  parameter int IDX_W     = 8,
  parameter int ACT_DELAY = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [1:0]       regAddr,
  input  logic [31:0]      regWrData,
  output logic [31:0]      regRdData,
  input  logic             slotReq,
  output logic             slotGrant,
  output logic             slotOvf,
  output logic [IDX_W-1:0] slotIdx,
  input  logic             recCommit,
  input  logic             memFaultIn
);

  localparam int BASE_W = PPN_W + LSZ_W;

  ringStrobe_t      strobe;
  logic             enQ;
  logic             onQ;
  logic             busyQ;
  logic             inflightZero;
  logic [PPN_W-1:0] ppnQ;
  logic [LSZ_W-1:0] lsm1Q;
  logic [IDX_W-1:0] headQ;
  logic [IDX_W-1:0] tailQ;
  logic             ovfQ;
  logic             mfQ;
  logic             baseWr;
  logic             headWr;
  logic             csrWr;
  logic             unusedWrBits;

  assign baseWr       = regWrEn && (regAddr == ADDR_BASE);
  assign headWr       = regWrEn && (regAddr == ADDR_HEAD);
  assign csrWr        = regWrEn && (regAddr == ADDR_CSR);
  assign unusedWrBits = ^regWrData[31:BASE_W];

  recRingCtrl #(.ACT_DELAY(ACT_DELAY)) i_ctrl (
    .clk(clk), .rstN(rstN), .csrWr(csrWr), .csrData(regWrData[2:0]),
    .inflightZero(inflightZero), .strobe(strobe), .enQ(enQ),
    .onOut(onQ), .busyOut(busyQ)
  );

  recRingDp #(.PPN_W(PPN_W), .LSZ_W(LSZ_W), .IDX_W(IDX_W)) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .baseWr(baseWr), .headWr(headWr),
    .wrData(regWrData[BASE_W-1:0]), .slotReq(slotReq), .recCommit(recCommit),
    .memFaultIn(memFaultIn), .slotGrant(slotGrant), .slotOvf(slotOvf),
    .slotIdx(slotIdx), .ppnQ(ppnQ), .lsm1Q(lsm1Q), .headQ(headQ), .tailQ(tailQ),
    .ovfQ(ovfQ), .mfQ(mfQ), .inflightZero(inflightZero)
  );

  always_comb begin
    regRdData = '0;
    unique case (regAddr)
      ADDR_BASE: regRdData = 32'({ppnQ, lsm1Q});
      ADDR_HEAD: regRdData = 32'(headQ);
      ADDR_TAIL: regRdData = 32'(tailQ);
      default: begin
        regRdData[CSR_EN]   = enQ;
        regRdData[CSR_OVF]  = ovfQ;
        regRdData[CSR_MF]   = mfQ;
        regRdData[CSR_ON]   = onQ;
        regRdData[CSR_BUSY] = busyQ;
      end
    endcase
  end

endmodule

// File: rtl/recRingChk.sv
module recRingChk #(
  parameter int IDX_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             regWrEn,
  input logic [1:0]       regAddr,
  input logic             slotGrant,
  input logic             slotOvf,
  input logic             recCommit,
  input logic [IDX_W-1:0] headQ,
  input logic [IDX_W-1:0] tailQ,
  input logic             ovfQ,
  input logic             mfQ,
  input logic             enQ,
  input logic             onQ,
  input logic             busyQ,
  input logic             inflightZero
);

  a_r2_base_clears_head: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn && regAddr == 2'd0 |=> headQ == '0);

  a_r3_tail_write_ignored: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn && regAddr == 2'd2 && !recCommit |=> $stable(tailQ));

  a_r4_activation_busy: assert property (@(posedge clk) disable iff (!rstN)
    $rose(enQ) |-> busyQ && !onQ);

  a_r5_busy_write_ignored: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn && regAddr == 2'd3 && busyQ |=> $stable(enQ));

  a_r6_grant_needs_on: assert property (@(posedge clk) disable iff (!rstN)
    slotGrant |-> onQ && !busyQ && enQ && !ovfQ && !mfQ);

  a_r8_grant_ovf_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(slotGrant && slotOvf));

  a_r8_ovf_sticks: assert property (@(posedge clk) disable iff (!rstN)
    slotOvf |=> ovfQ);

  a_r10_drain_on: assert property (@(posedge clk) disable iff (!rstN)
    $fell(enQ) |-> onQ && busyQ);

  a_r10_off_idle: assert property (@(posedge clk) disable iff (!rstN)
    !onQ && !busyQ |-> inflightZero);

endmodule

bind recRingCtl recRingChk #(.IDX_W(IDX_W)) i_recRingChk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
  .slotGrant(slotGrant), .slotOvf(slotOvf), .recCommit(recCommit),
  .headQ(headQ), .tailQ(tailQ), .ovfQ(ovfQ), .mfQ(mfQ), .enQ(enQ),
  .onQ(onQ), .busyQ(busyQ), .inflightZero(inflightZero)
);

// File: tb/test_recRingCtl.sv
module test_recRingCtl;

  localparam int CLK_P     = 10;
  localparam int IDX_W     = 8;
  localparam int ACT_DELAY = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic [1:0] regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic slotReq = 1'b0;
  logic slotGrant;
  logic slotOvf;
  logic [IDX_W-1:0] slotIdx;
  logic recCommit = 1'b0;
  logic memFaultIn = 1'b0;

  int nChk = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  recRingCtl #(.IDX_W(IDX_W), .ACT_DELAY(ACT_DELAY)) i_recRingCtl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .slotReq(slotReq),
    .slotGrant(slotGrant), .slotOvf(slotOvf), .slotIdx(slotIdx),
    .recCommit(recCommit), .memFaultIn(memFaultIn)
  );

  function automatic logic [31:0] csrExp(bit en, bit ovf, bit mf, bit on, bit busy);
    logic [31:0] v = '0;
    v[0] = en; v[1] = ovf; v[2] = mf; v[8] = on; v[9] = busy;
    return v;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    tick();
    regWrEn = 1'b0;
  endtask

  task automatic rdChk(string req, logic [1:0] a, logic [31:0] exp);
    regAddr = a;
    #1;
    check(req, regRdData, exp);
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog actual=hung expected=finished");
      finishRun();
    end
  end

  initial begin
    logic [31:0] baseVal;
    logic [IDX_W-1:0] mTail, mHead, mInfl, m;
    bit mOvf;
    void'($urandom(32'd2024));
    repeat (3) tick();
    rstN = 1'b1;
    tick();

    // R1 reset state
    rdChk("R1 base", 2'd0, 32'h0);
    rdChk("R1 head", 2'd1, 32'h0);
    rdChk("R1 tail", 2'd2, 32'h0);
    rdChk("R1 csr", 2'd3, 32'h0);

    // R2 base write, ring size 8
    baseVal = (32'h12345 << 5) | 32'd2;
    m = 8'h7;
    wr(2'd0, baseVal);
    rdChk("R2 base fields", 2'd0, baseVal);
    wr(2'd1, 32'd5);
    rdChk("R3 head plain", 2'd1, 32'd5);
    wr(2'd0, baseVal);
    rdChk("R2 head zeroed", 2'd1, 32'd0);

    // R3 masking and read-only tail
    wr(2'd1, 32'hFF);
    rdChk("R3 head masked", 2'd1, 32'd7);
    wr(2'd2, 32'd3);
    rdChk("R3 tail write ignored", 2'd2, 32'd0);
    wr(2'd1, 32'd0);

    // R4 activation
    wr(2'd3, 32'd1);
    rdChk("R4 activating", 2'd3, csrExp(1, 0, 0, 0, 1));
    for (int i = 1; i < ACT_DELAY; i++) begin
      tick();
      rdChk("R4 still activating", 2'd3, csrExp(1, 0, 0, 0, 1));
    end
    tick();
    rdChk("R4 active", 2'd3, csrExp(1, 0, 0, 1, 0));

    // R6 fill a ring of 8 with head 0: seven grants
    slotReq = 1'b1;
    for (int i = 0; i < 7; i++) begin
      #1;
      check("R6 grant", {31'd0, slotGrant}, 32'd1);
      check("R6 index", 32'(slotIdx), 32'(i));
      tick();
    end
    #1;
    check("R8 full no grant", {31'd0, slotGrant}, 32'd0);
    check("R8 overflow pulse", {31'd0, slotOvf}, 32'd1);
    tick();
    slotReq = 1'b0;
    rdChk("R8 overflow flag", 2'd3, csrExp(1, 1, 0, 1, 0));

    // R7 commits
    recCommit = 1'b1;
    repeat (7) tick();
    rdChk("R7 tail after seven", 2'd2, 32'd7);
    tick();
    recCommit = 1'b0;
    rdChk("R7 commit with none in flight", 2'd2, 32'd7);

    slotReq = 1'b1;
    #1;
    check("R8 blocked while overflow", {31'd0, slotGrant, slotOvf}, 32'd0);
    slotReq = 1'b0;
    wr(2'd1, 32'd7);
    wr(2'd3, 32'h3);
    rdChk("R9 overflow cleared", 2'd3, csrExp(1, 0, 0, 1, 0));
    slotReq = 1'b1;
    #1;
    check("R6 grant at top index", 32'(slotIdx), 32'd7);
    check("R6 grant at top", {31'd0, slotGrant}, 32'd1);
    tick();
    slotReq = 1'b0;
    recCommit = 1'b1;
    tick();
    recCommit = 1'b0;
    rdChk("R7 tail wraps", 2'd2, 32'd0);

    // R9 memory fault
    memFaultIn = 1'b1;
    tick();
    memFaultIn = 1'b0;
    rdChk("R9 fault flag", 2'd3, csrExp(1, 0, 1, 1, 0));
    slotReq = 1'b1;
    #1;
    check("R9 fault blocks", {31'd0, slotGrant}, 32'd0);
    slotReq = 1'b0;
    wr(2'd3, 32'h5);
    rdChk("R9 fault cleared", 2'd3, csrExp(1, 0, 0, 1, 0));

    // R10 drain with two outstanding
    slotReq = 1'b1;
    tick(); tick();
    slotReq = 1'b0;
    wr(2'd3, 32'd0);
    rdChk("R10 draining", 2'd3, csrExp(0, 0, 0, 1, 1));
    slotReq = 1'b1;
    #1;
    check("R10 no grant while draining", {31'd0, slotGrant}, 32'd0);
    slotReq = 1'b0;
    wr(2'd3, 32'd1);
    rdChk("R5 write while busy ignored", 2'd3, csrExp(0, 0, 0, 1, 1));
    recCommit = 1'b1;
    tick();
    rdChk("R10 still draining", 2'd3, csrExp(0, 0, 0, 1, 1));
    tick();
    recCommit = 1'b0;
    rdChk("R10 last commit cycle", 2'd3, csrExp(0, 0, 0, 1, 1));
    tick();
    rdChk("R10 off", 2'd3, csrExp(0, 0, 0, 0, 0));
    rdChk("R7 tail after drain", 2'd2, 32'd2);

    // R4 enable clears flags and tail
    memFaultIn = 1'b1;
    tick();
    memFaultIn = 1'b0;
    rdChk("R9 fault while off", 2'd3, csrExp(0, 0, 1, 0, 0));
    wr(2'd3, 32'd1);
    rdChk("R4 flags cleared", 2'd3, csrExp(1, 0, 0, 0, 1));
    rdChk("R4 tail zeroed", 2'd2, 32'd0);
    repeat (ACT_DELAY) tick();
    rdChk("R4 on again", 2'd3, csrExp(1, 0, 0, 1, 0));

    // random phase: R6 R7 R8 R9 against a model
    mTail = 0; mHead = 7; mInfl = 0; mOvf = 0;
    for (int c = 0; c < 4000; c++) begin
      bit req, cmt, headW, clrW, expG, expO, full, cOk;
      logic [IDX_W-1:0] alloc;
      int op;
      req = ($urandom_range(0, 1) == 1);
      cmt = ($urandom_range(0, 2) == 0);
      op = $urandom_range(0, 15);
      headW = (op < 3);
      clrW = (op == 3);
      slotReq = req;
      recCommit = cmt;
      regWrEn = headW || clrW;
      regAddr = headW ? 2'd1 : 2'd3;
      regWrData = headW ? 32'(mTail) : 32'h3;
      #1;
      alloc = (mTail + mInfl) & m;
      full = (((alloc + 1'b1) & m) == mHead);
      expG = req && !mOvf && !full;
      expO = req && !mOvf && full;
      check("R6 random grant", {31'd0, slotGrant}, {31'd0, expG});
      check("R8 random overflow", {31'd0, slotOvf}, {31'd0, expO});
      if (expG) check("R6 random index", 32'(slotIdx), 32'(alloc));
      cOk = cmt && (mInfl != 0);
      @(posedge clk);
      if (headW) mHead = mTail & m;
      if (cOk) mTail = (mTail + 1'b1) & m;
      mInfl = mInfl + (expG ? 1'b1 : 1'b0) - (cOk ? 1'b1 : 1'b0);
      if (expO) mOvf = 1'b1;
      else if (clrW) mOvf = 1'b0;
      #1;
    end
    slotReq = 1'b0;
    recCommit = 1'b0;
    regWrEn = 1'b0;
    rdChk("R7 random tail", 2'd2, 32'(mTail));
    rdChk("R8 random flag", 2'd3, csrExp(1, mOvf, 0, 1, 0));

    // R3 size field beyond index width clamps mask to IDX_W bits
    wr(2'd0, 32'd20);
    wr(2'd1, 32'h1FF);
    rdChk("R3 head mask clamped", 2'd1, 32'hFF);

    done = 1'b1;
    finishRun();
  end

endmodule